// File: doc/BRIEF.md
# Self-Timed Nonvolatile Nibble Store Write Sequencer

This block sits between a CPU data bus and a 1024-word by 4-bit nonvolatile data array that occupies the data address window 400H to 7FFH. Software reads and writes the window like static RAM. An access is either one nibble wide or one byte wide. A byte access covers an aligned even/odd nibble pair.

Reads are combinational and are always available. A write needs no software sequencing. Once a write is accepted, the block latches the target and the data and raises a busy flag. It then runs an erase phase and a program phase on its own, each timed by a number of clock-enable ticks (by default 4 plus 6 ticks of a 1 ms enable, giving 10 ms). At the end it commits the new data and raises a write-complete request.

A write issued while the block is busy is dropped and raises a separate overwrite request instead. Both request flags hold until software clears them with a one-cycle clear pulse.

Top module: `nvm_write_seq`

## Requirements
- R1: Only addresses whose upper two bits are 01 (400H to 7FFH) select the array. A write outside this window starts nothing and changes nothing, and a read outside it returns 00H.
- R2: A nibble access (`accWide`=0) addresses word `addr[9:0]`. A nibble read returns that word on `rdData[3:0]`, with `rdData[7:4]` = 0.
- R3: A byte access (`accWide`=1) ignores `addr[0]`. The even word maps to `rdData[3:0]`/`wrData[3:0]` and the odd word maps to `rdData[7:4]`/`wrData[7:4]`. A byte write updates both words in one cycle.
- R4: A write that hits the window while the block is idle sets `busy` on the next clock. `busy` stays high for exactly ERASE_TICKS+PROG_TICKS cycles with `tickEn`=1, and falls on the clock that samples the last of those ticks.
- R5: During the first ERASE_TICKS ticks of a cycle, reads of the target word or words return all ones (F).
- R6: During the program phase, the target word reads its old value. The new value becomes visible in the cycle after `busy` falls.
- R7: `irqDone` sets on the clock where `busy` falls.
- R8: A write that hits the window while `busy` is high sets `irqOvw` on the next clock. The stored data, the target and the timing of the running cycle are not affected.
- R9: `irqDone` and `irqOvw` stay set until their clear input is high at a clock edge. A set and a clear in the same cycle leave the flag set.
- R10: Reset forces `busy`, `irqDone` and `irqOvw` low and abandons a running cycle without committing it. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timebase enable that paces the write cycle |
| addr | input | 12 | Data address for reads and writes |
| accWide | input | 1 | 1 = byte access, 0 = nibble access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data (nibble accesses use bits 3:0) |
| rdData | output | 8 | Combinational read data |
| busy | output | 1 | Write cycle in progress |
| irqDone | output | 1 | Sticky write-complete request |
| irqOvw | output | 1 | Sticky overwrite request |
| clrDone | input | 1 | Clear pulse for irqDone |
| clrOvw | input | 1 | Clear pulse for irqOvw |

## Verification
The hardest situations to reach are the collisions at the edges of a write cycle. The first is a second write landing on the very tick that completes the first. The second is a clear pulse held across the completion edge. The third is a reset arriving in mid-erase. In all three cases the result depends on which of two events wins in one cycle.

The stimulus holds the read address on the target through whole cycles and spaces the enable ticks out. As a result, every cycle of the erase, program and commit sequence is compared against the reference model. It then issues repeated writes, holds a clear across the completion, and drops reset part way through an erase.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic startWr;   // latch target, width and data
    logic commit;    // write latched data into the array
    logic eraseAct;  // erase phase: target reads as all ones
  } nvmStrb_t;
endpackage

// File: rtl/nvm_ctl.sv
module nvm_ctl
  import nvm_pkg::*;
#(
  parameter int ERASE_TICKS = 4,
  parameter int PROG_TICKS  = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     wrHit,
  input  logic     clrDone,
  input  logic     clrOvw,
  output nvmStrb_t strb,
  output logic     busy,
  output logic     irqDone,
  output logic     irqOvw
);
  localparam int MAXT = (ERASE_TICKS > PROG_TICKS) ? ERASE_TICKS : PROG_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG} phase_t;

  phase_t        phase;
  logic [CW-1:0] tickCnt;
  logic          eraseLast;
  logic          progLast;

  always_comb begin
    eraseLast     = (phase == ST_ERASE) && tickEn && (tickCnt == CW'(ERASE_TICKS - 1));
    progLast      = (phase == ST_PROG)  && tickEn && (tickCnt == CW'(PROG_TICKS - 1));
    busy          = (phase != ST_IDLE);
    strb.startWr  = wrHit && (phase == ST_IDLE);
    strb.commit   = progLast;
    strb.eraseAct = (phase == ST_ERASE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      tickCnt <= '0;
      irqDone <= 1'b0;
      irqOvw  <= 1'b0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          if (strb.startWr) begin
            phase   <= ST_ERASE;
            tickCnt <= '0;
          end
        end
        ST_ERASE: begin
          if (eraseLast) begin
            phase   <= ST_PROG;
            tickCnt <= '0;
          end else if (tickEn) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (progLast) begin
            phase   <= ST_IDLE;
            tickCnt <= '0;
          end else if (tickEn) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
      // set wins over clear
      irqDone <= progLast | (irqDone & ~clrDone);
      irqOvw  <= (wrHit & busy) | (irqOvw & ~clrOvw);
    end
  end
endmodule

// File: rtl/nvm_dp.sv
module nvm_dp
  import nvm_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          IDX_W  = 10,
  parameter int          NIB    = 4,
  parameter logic [11:0] BASE   = 12'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              accWide,
  input  logic [2*NIB-1:0]  wrData,
  input  nvmStrb_t          strb,
  output logic              addrHit,
  output logic [2*NIB-1:0]  rdData
);
  localparam int WORDS = 1 << IDX_W;
  localparam int TOP_W = ADDR_W - IDX_W;
  localparam logic [TOP_W-1:0] BASE_TOP = BASE[ADDR_W-1:IDX_W];

  logic [NIB-1:0]   mem [WORDS];
  logic [IDX_W-1:0] tgtIdx;
  logic             tgtWide;
  logic [2*NIB-1:0] tgtData;

  logic [IDX_W-1:0] idxLo, idxHi, tgtOdd;
  logic [NIB-1:0]   nibLo, nibHi;
  logic             loErased, hiErased;

  always_comb begin
    addrHit  = (addr[ADDR_W-1:IDX_W] == BASE_TOP);
    idxLo    = accWide ? {addr[IDX_W-1:1], 1'b0} : addr[IDX_W-1:0];
    idxHi    = {addr[IDX_W-1:1], 1'b1};
    tgtOdd   = {tgtIdx[IDX_W-1:1], 1'b1};
    loErased = strb.eraseAct && ((idxLo == tgtIdx) || (tgtWide && idxLo == tgtOdd));
    hiErased = strb.eraseAct && ((idxHi == tgtIdx) || (tgtWide && idxHi == tgtOdd));
    nibLo    = loErased ? {NIB{1'b1}} : mem[idxLo];
    nibHi    = hiErased ? {NIB{1'b1}} : mem[idxHi];
    if (!addrHit)     rdData = '0;
    else if (accWide) rdData = {nibHi, nibLo};
    else              rdData = {{NIB{1'b0}}, nibLo};
  end

  // target and data latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtIdx  <= '0;
      tgtWide <= 1'b0;
      tgtData <= '0;
    end else if (strb.startWr) begin
      tgtIdx  <= idxLo;
      tgtWide <= accWide;
      tgtData <= wrData;
    end
  end

  // array model: contents survive reset
  always_ff @(posedge clk) begin
    if (strb.commit) begin
      mem[tgtIdx] <= tgtData[NIB-1:0];
      if (tgtWide) mem[tgtOdd] <= tgtData[2*NIB-1:NIB];
    end
  end
endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
  import nvm_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          IDX_W       = 10,
  parameter int          NIB         = 4,
  parameter logic [11:0] BASE        = 12'h400,
  parameter int          ERASE_TICKS = 4,
  parameter int          PROG_TICKS  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              accWide,
  input  logic              wrEn,
  input  logic [2*NIB-1:0]  wrData,
  output logic [2*NIB-1:0]  rdData,
  output logic              busy,
  output logic              irqDone,
  output logic              irqOvw,
  input  logic              clrDone,
  input  logic              clrOvw
);
  nvmStrb_t strb;
  logic     addrHit;
  logic     wrHit;

  assign wrHit = wrEn & addrHit;

  nvm_ctl #(.ERASE_TICKS(ERASE_TICKS), .PROG_TICKS(PROG_TICKS)) u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrHit(wrHit),
    .clrDone(clrDone), .clrOvw(clrOvw), .strb(strb),
    .busy(busy), .irqDone(irqDone), .irqOvw(irqOvw)
  );

  nvm_dp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NIB(NIB), .BASE(BASE)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .accWide(accWide),
    .wrData(wrData), .strb(strb), .addrHit(addrHit), .rdData(rdData)
  );
endmodule

// File: rtl/nvm_write_seq_chk.sv
module nvm_write_seq_chk #(
  parameter int          ADDR_W = 12,
  parameter int          IDX_W  = 10,
  parameter logic [11:0] BASE   = 12'h400,
  parameter int          TOTAL  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              busy,
  input logic              irqDone,
  input logic              irqOvw,
  input logic              clrDone,
  input logic              clrOvw
);
  localparam int CW = $clog2(TOTAL + 1);
  logic          inWin;
  logic [CW-1:0] tickSeen;

  assign inWin = (addr[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tickSeen <= '0;
    else if (!busy)         tickSeen <= '0;
    else if (tickEn)        tickSeen <= tickSeen + 1'b1;
  end

  // R4: idle write in window starts a cycle
  a_r4_start: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && inWin && !busy) |=> busy);
  // R4: cycle ends on the last tick
  a_r4_length: assert property (@(posedge clk) disable iff (!rstN)
    (busy && tickEn && tickSeen == CW'(TOTAL - 1)) |=> !busy);
  // R4: no early end
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(tickEn && tickSeen == CW'(TOTAL - 1))) |=> busy);
  // R1: out-of-window write never starts a cycle
  a_r1_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inWin && !busy) |=> !busy);
  // R7: completion request accompanies the end of busy
  a_r7_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irqDone);
  // R8: overwrite request
  a_r8_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && inWin && busy) |=> irqOvw);
  // R9: sticky flags
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqDone && !clrDone) |=> irqDone);
  a_r9_ovw_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqOvw && !clrOvw) |=> irqOvw);
  // R10: reset state
  a_r10_reset: assert property (@(posedge clk)
    !rstN |=> (!busy && !irqDone && !irqOvw));
endmodule

bind nvm_write_seq nvm_write_seq_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE), .TOTAL(ERASE_TICKS + PROG_TICKS)
) u_chk (.*);

// File: tb/test_nvm_write_seq.sv
`timescale 1ns/1ps
module test_nvm_write_seq;
  localparam int E = 4;
  localparam int P = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [11:0] addr = '0;
  logic        accWide = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        busy, irqDone, irqOvw;
  logic        clrDone = 1'b0;
  logic        clrOvw = 1'b0;

  always #4 clk = ~clk;

  nvm_write_seq #(.ERASE_TICKS(E), .PROG_TICKS(P)) i_nvm_write_seq (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .accWide(accWide),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .busy(busy),
    .irqDone(irqDone), .irqOvw(irqOvw), .clrDone(clrDone), .clrOvw(clrOvw)
  );

  // ---------------- reference model ----------------
  logic [3:0] mMem [1024];
  bit         mKnown [1024];
  bit         mBusy, mErase, mDone, mOvw, mWide;
  int         mCnt, mIdx;
  logic [7:0] mData;

  always @(posedge clk) begin : model
    bit hit, setD, setO;
    if (!rstN) begin
      mBusy = 0; mErase = 0; mDone = 0; mOvw = 0; mCnt = 0;
    end else begin
      hit  = (addr >= 12'h400) && (addr <= 12'h7FF);
      setO = wrEn && hit && mBusy;
      setD = 0;
      if (mBusy) begin
        if (tickEn) begin
          mCnt++;
          if (mErase && mCnt == E) begin
            mErase = 0; mCnt = 0;
          end else if (!mErase && mCnt == P) begin
            mMem[mIdx] = mData[3:0]; mKnown[mIdx] = 1;
            if (mWide) begin mMem[mIdx+1] = mData[7:4]; mKnown[mIdx+1] = 1; end
            mBusy = 0; setD = 1;
          end
        end
      end else if (wrEn && hit) begin
        mBusy = 1; mErase = 1; mCnt = 0; mWide = accWide; mData = wrData;
        mIdx = accWide ? int'(addr[9:0]) & ~1 : int'(addr[9:0]);
      end
      if (clrDone) mDone = 0;
      if (setD)    mDone = 1;
      if (clrOvw)  mOvw = 0;
      if (setO)    mOvw = 1;
    end
  end

  function automatic bit modelNib(input int idx, output logic [3:0] v);
    if (mBusy && mErase && (idx == mIdx || (mWide && idx == mIdx + 1))) begin
      v = 4'hF; return 1;
    end
    v = mMem[idx];
    return mKnown[idx];
  endfunction

  // ---------------- checking ----------------
  int    checks = 0;
  int    errors = 0;
  string curReq = "R10";
  int    cycN = 0;
  int    tickPer = 1;

  task automatic chk1(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h (t=%0t)", curReq, what, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [3:0] lo, hi;
    bit vLo, vHi;
    int base;
    chk1("busy", busy, mBusy);
    chk1("irqDone", irqDone, mDone);
    chk1("irqOvw", irqOvw, mOvw);
    if (addr < 12'h400 || addr > 12'h7FF) begin
      chk1("rdData outside window", rdData, 0);
    end else if (accWide) begin
      base = int'(addr[9:0]) & ~1;
      vLo = modelNib(base, lo);
      vHi = modelNib(base + 1, hi);
      if (vLo && vHi) chk1("rdData byte", rdData, {hi, lo});
    end else begin
      vLo = modelNib(int'(addr[9:0]), lo);
      if (vLo) chk1("rdData nibble", rdData, {4'h0, lo});
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compareAll();
    cycN++;
    tickEn = (tickPer == 1) ? 1'b1 : (cycN % tickPer == 0);
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 2000 && mBusy; k++) cyc();
    cyc();
  endtask

  task automatic doWrite(input logic [11:0] a, input logic w, input logic [7:0] d);
    addr = a; accWide = w; wrData = d; wrEn = 1'b1;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a, input logic w);
    addr = a; accWide = w;
    cyc();
  endtask

  initial begin
    // R10: reset state
    curReq = "R10";
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R2 / R4 / R7: nibble writes with a tick every cycle
    curReq = "R4";
    for (int i = 0; i < 16; i++) begin
      doWrite(12'h400 + 12'(i), 1'b0, 8'((i * 7 + 3) & 15));
      waitIdle();
    end
    curReq = "R7";
    clrDone = 1'b1; cyc(); clrDone = 1'b0; cyc();
    curReq = "R2";
    for (int i = 0; i < 16; i++) doRead(12'h400 + 12'(i), 1'b0);

    // R3: byte write at an odd address aligns to the even word
    curReq = "R3";
    doWrite(12'h421, 1'b1, 8'hA5);
    waitIdle();
    doRead(12'h420, 1'b1);
    doRead(12'h421, 1'b1);
    doRead(12'h420, 1'b0);
    doRead(12'h421, 1'b0);
    doWrite(12'h7FE, 1'b1, 8'h3C);
    waitIdle();
    doRead(12'h7FF, 1'b1);

    // R5 / R6: sparse ticks, read address held on the target
    curReq = "R5";
    tickPer = 3;
    doWrite(12'h405, 1'b0, 8'h0C);
    for (int k = 0; k < 3 * E; k++) cyc();
    curReq = "R6";
    waitIdle();
    doRead(12'h405, 1'b0);
    curReq = "R5";
    doWrite(12'h40A, 1'b1, 8'h96);
    curReq = "R6";
    waitIdle();
    doRead(12'h40B, 1'b0);

    // R8: overwrite while busy is dropped
    curReq = "R8";
    tickPer = 2;
    doWrite(12'h406, 1'b0, 8'h01);
    doWrite(12'h406, 1'b0, 8'h07);
    doWrite(12'h40F, 1'b1, 8'hEE);
    for (int k = 0; k < 40 && mBusy; k++) begin
      if (mCnt == P - 1 && !mErase && tickEn) wrEn = 1'b1;
      addr = 12'h406; accWide = 1'b0; wrData = 8'h0B;
      cyc();
      wrEn = 1'b0;
    end
    waitIdle();
    doRead(12'h406, 1'b0);
    doRead(12'h40E, 1'b1);

    // R9: sticky flags, set beats clear
    curReq = "R9";
    repeat (3) cyc();
    clrOvw = 1'b1; cyc(); clrOvw = 1'b0; cyc();
    clrDone = 1'b1;
    doWrite(12'h408, 1'b0, 8'h05);
    waitIdle();
    repeat (2) cyc();
    clrDone = 1'b0;
    cyc(); cyc();

    // R1: outside the window
    curReq = "R1";
    tickPer = 1;
    doWrite(12'h3FF, 1'b0, 8'h0F);
    doWrite(12'h800, 1'b1, 8'hFF);
    doRead(12'h100, 1'b1);
    doRead(12'h800, 1'b0);
    doRead(12'h400, 1'b0);

    // R10: reset in mid-erase abandons the cycle
    curReq = "R10";
    tickPer = 2;
    doWrite(12'h407, 1'b0, 8'h09);
    cyc(); cyc();
    rstN = 1'b0;
    cyc(); cyc();
    rstN = 1'b1;
    doRead(12'h407, 1'b0);
    doRead(12'h407, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule